// File: doc/BRIEF.md
# IO Page Table Translation Walker

This block turns DMA I/O virtual addresses into physical addresses for a bus bridge. A requester hands it a virtual address. The block returns three things: a byte address, a page-offset mask, and a permission code. When translation is off, the address passes straight through as read-write with an 8 KB offset mask.

When translation is on, the block finds the table entry and reads it. It builds an index from the virtual address, the 3-bit table-size code and the table-granularity bit. It adds that index to the table base and issues one 64-bit read on its memory master port. It then decodes the returned entry. Each entry carries its own page-size bit, so 8 KB and 64 KB pages can sit in the same table.

A separate register block supplies the control fields and the table base as plain inputs. Only one translation is in flight at a time. Requests, memory reads and results each use a valid/ready handshake.

Top module: `iopt_walker`

## Requirements
- R1: With `xlat_en_i` low, a request returns its own address unchanged, mask 0x1FFF and permission code 2'b11 (read-write), and no memory read is issued.
- R2: With `tbl_64k_i` low and size code c (0..7), the entry read address is base + 8 × (va[22+c:13]).
- R3: With `tbl_64k_i` high and size code c (0..5), the entry read address is base + 8 × (va[25+c:16]).
- R4: With `tbl_64k_i` high and size code 6 or 7, the result is permission 2'b00 (none), address 0 and mask all ones, and no memory read is issued.
- R5: An entry whose bit 63 is clear gives permission 2'b00, address 0 and mask all ones.
- R6: For a valid entry, bit 1 set gives permission 2'b11 (read-write); bit 1 clear gives 2'b01 (read-only). The code 2'b10 is never returned.
- R7: For a valid entry with bit 61 set (64 KB page), the mask is 0xFFFF and the address is (entry AND 0x1FFFFFF0000) OR (va AND 0xFFFF).
- R8: For a valid entry with bit 61 clear (8 KB page), the mask is 0x1FFF and the address is (entry AND 0x1FFFFFFE000) OR (va AND 0x1FFF).
- R9: The following handshake rules hold:
  - `req_ready_o` stays low from acceptance until the result handshake completes.
  - A memory request, once raised, holds its address until it is accepted.
  - A result, once raised, holds its value until it is accepted.
- R10: After reset the block is idle: `req_ready_o` is high, and `mem_req_valid_o` and `rsp_valid_o` are low.
- R11: An enabled translation with a supported size code issues exactly one memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Translation enable (control field) |
| tbl_64k_i | input | 1 | Table granularity: 1 = 64 KB steps, 0 = 8 KB steps |
| tbl_size_i | input | 3 | Table-size code |
| tbl_base_i | input | ADDR_W | Table base address |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Ready for a request |
| req_addr_i | input | ADDR_W | Virtual address to translate |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_addr_o | output | ADDR_W | Entry read address |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 64 | Entry data, bit 63 most significant |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_addr_o | output | ADDR_W | Translated byte address |
| rsp_mask_o | output | ADDR_W | Page-offset mask |
| rsp_perm_o | output | 2 | Permission: 00 none, 01 read-only, 11 read-write |

## Verification
A wrong index calculation shows on `mem_addr_o` in the first cycle the read request is raised. This happens before any entry data comes back. A wrong entry decode, or a stale latched address, shows on the result one cycle after the read data arrives. A stuck or misrouted state shows either as a read where none is due, or as a missing one, which the bench detects when the translation completes. The same fault can also show as a held `req_ready_o`, which stalls the next request.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int unsigned ENTRY_W   = 64;
  localparam int unsigned VALID_BIT = 63;
  localparam int unsigned PG64_BIT  = 61;
  localparam int unsigned WR_BIT    = 1;
  localparam int unsigned PA_MSB    = 40;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/iopt_index.sv
module iopt_index #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              gran_64k_i,
  input  logic [2:0]        size_i,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic              unsup_o
);
  int lo, hi, sh;
  logic [ADDR_W-1:0] sel_mask;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    lo = gran_64k_i ? 16 : 13;
    hi = (gran_64k_i ? 25 : 22) + int'(size_i);
    sh = gran_64k_i ? 13 : 10;
    for (int i = 0; i < int'(ADDR_W); i++) begin
      sel_mask[i] = (i >= lo) && (i <= hi);
    end
    offs       = (va_i & sel_mask) >> sh;
    tbl_addr_o = base_i + offs;
    unsup_o    = gran_64k_i && (size_i >= 3'd6);
  end
endmodule

// File: rtl/iopt_decode.sv
module iopt_decode
  import iopt_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [ADDR_W-1:0]  va_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [ADDR_W-1:0]  mask_o,
  output perm_e              perm_o
);
  logic [ENTRY_W-1:0] pa_mask;
  logic [ENTRY_W-1:0] frame;
  logic [ADDR_W-1:0]  off_mask;
  logic               page64;

  always_comb begin
    page64 = entry_i[PG64_BIT];
    for (int i = 0; i < int'(ENTRY_W); i++) begin
      pa_mask[i] = (i >= (page64 ? 15 : 13)) && (i <= int'(PA_MSB));
    end
    frame    = entry_i & pa_mask;
    off_mask = page64 ? ADDR_W'(16'hFFFF) : ADDR_W'(16'h1FFF);
    if (!entry_i[VALID_BIT]) begin
      addr_o = '0;
      mask_o = '1;
      perm_o = PERM_NONE;
    end else begin
      // page frame bits, offset bits taken from the request address
      addr_o = (ADDR_W'(frame) & ~off_mask) | (va_i & off_mask);
      mask_o = off_mask;
      perm_o = entry_i[WR_BIT] ? PERM_RW : PERM_RO;
    end
  end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xlat_en_i,
  input  logic               tbl_64k_i,
  input  logic [2:0]         tbl_size_i,
  input  logic [ADDR_W-1:0]  tbl_base_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0] mem_rsp_data_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [ADDR_W-1:0]  rsp_addr_o,
  output logic [ADDR_W-1:0]  rsp_mask_o,
  output logic [1:0]         rsp_perm_o
);
  localparam logic [ADDR_W-1:0] PASS_MASK = ADDR_W'(16'h1FFF);

  walk_st_e          st_q;
  logic [ADDR_W-1:0] va_q, tbl_q, res_addr_q, res_mask_q;
  perm_e             res_perm_q;

  logic [ADDR_W-1:0] idx_addr, dec_addr, dec_mask;
  logic              idx_unsup;
  perm_e             dec_perm;

  iopt_index #(.ADDR_W(ADDR_W)) u_index (
    .va_i       (req_addr_i),
    .base_i     (tbl_base_i),
    .gran_64k_i (tbl_64k_i),
    .size_i     (tbl_size_i),
    .tbl_addr_o (idx_addr),
    .unsup_o    (idx_unsup)
  );

  iopt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .entry_i (mem_rsp_data_i),
    .va_i    (va_q),
    .addr_o  (dec_addr),
    .mask_o  (dec_mask),
    .perm_o  (dec_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      tbl_q      <= '0;
      res_addr_q <= '0;
      res_mask_q <= '0;
      res_perm_q <= PERM_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q <= req_addr_i;
          if (!xlat_en_i) begin
            res_addr_q <= req_addr_i;
            res_mask_q <= PASS_MASK;
            res_perm_q <= PERM_RW;
            st_q       <= ST_RESP;
          end else if (idx_unsup) begin
            res_addr_q <= '0;
            res_mask_q <= '1;
            res_perm_q <= PERM_NONE;
            st_q       <= ST_RESP;
          end else begin
            tbl_q <= idx_addr;
            st_q  <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_req_ready_i) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid_i) begin
          res_addr_q <= dec_addr;
          res_mask_q <= dec_mask;
          res_perm_q <= dec_perm;
          st_q       <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_RD_REQ);
  assign mem_addr_o      = tbl_q;
  assign rsp_valid_o     = (st_q == ST_RESP);
  assign rsp_addr_o      = res_addr_q;
  assign rsp_mask_o      = res_mask_q;
  assign rsp_perm_o      = res_perm_q;
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [ADDR_W-1:0] rsp_addr_o,
  input logic [ADDR_W-1:0] rsp_mask_o,
  input logic [1:0]        rsp_perm_o
);
  // R9
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_valid_o) |-> !req_ready_o);
  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));
  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_mask_o) && $stable(rsp_perm_o)));
  // R9
  single_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && mem_req_valid_o));
  // R5
  none_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_perm_o == 2'b00) |-> (rsp_addr_o == '0 && rsp_mask_o == '1));
  // R6
  perm_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_perm_o != 2'b10));
endmodule

bind iopt_walker iopt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_addr_o      (mem_addr_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_addr_o      (rsp_addr_o),
  .rsp_mask_o      (rsp_mask_o),
  .rsp_perm_o      (rsp_perm_o)
);

// File: tb/iopt_walker_tb.sv
module iopt_walker_tb_top;
  localparam int unsigned ADDR_W = 64;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [63:0] addr;
    logic [63:0] mask;
    logic [1:0]  perm;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic xlat_en = 0, tbl_64k = 0;
  logic [2:0] tbl_size = 0;
  logic [63:0] tbl_base = 0, req_addr = 0, mem_data = 0;
  logic req_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0, rsp_ready = 0;
  logic req_ready, mem_req_valid, rsp_valid;
  logic [63:0] mem_addr, rsp_addr, rsp_mask;
  logic [1:0] rsp_perm;

  int n_chk = 0, n_bad = 0, rd_cnt = 0;
  bit done = 0;
  exp_t sb_q[$];
  logic [63:0] cur_entry, exp_maddr;
  string maddr_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  iopt_walker #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xlat_en_i(xlat_en), .tbl_64k_i(tbl_64k),
    .tbl_size_i(tbl_size), .tbl_base_i(tbl_base), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_addr_i(req_addr), .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_req_ready), .mem_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_data), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_addr_o(rsp_addr), .rsp_mask_o(rsp_mask), .rsp_perm_o(rsp_perm)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result of a valid/invalid entry, from R5..R8
  task automatic entry_exp(input logic [63:0] e, input logic [63:0] va, output exp_t x);
    if (!e[63]) begin
      x.addr = 0; x.mask = '1; x.perm = 2'b00;
    end else begin
      x.perm = e[1] ? 2'b11 : 2'b01;
      if (e[61]) begin
        x.mask = 64'hFFFF;
        x.addr = (e & 64'h1FF_FFFF_0000) | (va & 64'hFFFF);
      end else begin
        x.mask = 64'h1FFF;
        x.addr = (e & 64'h1FF_FFFF_E000) | (va & 64'h1FFF);
      end
    end
  endtask

  task automatic run(input logic en, input logic g64, input logic [2:0] code,
                     input logic [63:0] base, input logic [63:0] va,
                     input logic [63:0] entry, input string tag);
    exp_t x;
    int rd0;
    logic [63:0] idx;
    bit rd_due;
    rd_due = en && !(g64 && code >= 3'd6);
    if (!en) begin
      x.addr = va; x.mask = 64'h1FFF; x.perm = 2'b11;
    end else if (!rd_due) begin
      x.addr = 0; x.mask = '1; x.perm = 2'b00;
    end else begin
      entry_exp(entry, va, x);
    end
    x.tag = tag;
    idx = g64 ? ((va >> 16) & ((64'd1 << (10 + code)) - 1))
              : ((va >> 13) & ((64'd1 << (10 + code)) - 1));
    exp_maddr = base + (idx << 3);
    maddr_tag = g64 ? "R3 entry address" : "R2 entry address";
    cur_entry = entry;
    sb_q.push_back(x);
    rd0 = rd_cnt;
    @(posedge clk); #1;
    xlat_en = en; tbl_64k = g64; tbl_size = code; tbl_base = base;
    req_addr = va; req_valid = 1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 0;
    while (sb_q.size() != 0) @(negedge clk);
    chk((rd_cnt - rd0) == (rd_due ? 1 : 0), rd_due ? "R11 one read" : "R1/R4 no read",
        64'(rd_cnt - rd0), rd_due ? 64'd1 : 64'd0);
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) chk(0, "R9 unexpected result", rsp_addr, 0);
      else begin
        exp_t x;
        x = sb_q.pop_front();
        chk(rsp_addr == x.addr, {x.tag, " addr"}, rsp_addr, x.addr);
        chk(rsp_mask == x.mask, {x.tag, " mask"}, rsp_mask, x.mask);
        chk(rsp_perm == x.perm, {x.tag, " perm"}, 64'(rsp_perm), 64'(x.perm));
      end
    end
  end

  // memory responder
  initial forever begin
    @(negedge clk);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      chk(mem_addr == exp_maddr, maddr_tag, mem_addr, exp_maddr);
      rd_cnt++;
      @(posedge clk);
      @(posedge clk); #1;
      mem_data = cur_entry; mem_rsp_valid = 1;
      @(posedge clk); #1 mem_rsp_valid = 0;
    end
  end

  // backpressure patterns
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      mem_req_ready = (c % 3) != 0;
      rsp_ready = (c % 4) != 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 1);
    chk(mem_req_valid == 1'b0, "R10 mem_req_valid", 64'(mem_req_valid), 0);
    chk(rsp_valid == 1'b0, "R10 rsp_valid", 64'(rsp_valid), 0);
    rst_n = 1;
    // R1 passthrough
    run(0, 0, 3'd0, 64'h0, 64'h0000_1234_5678_9ABC, 64'h0, "R1 passthrough");
    // R2 R8 R6: 8K table, 8K page, writable
    run(1, 0, 3'd0, 64'h10_0000, 64'h0000_0000_00A5_6789,
        64'h8000_0000_0ABC_D002, "R2 R8 R6 rw 8k");
    // R2 high code, upper va bits must be ignored; junk bits in entry
    run(1, 0, 3'd7, 64'h2000_0000, 64'hFFFF_FFF3_DEAD_BEEF,
        64'h9E00_FFF5_5555_5FFC, "R2 R8 R6 ro code7 junk");
    // R3 R7 64K table, 64K page, read-only
    run(1, 1, 3'd0, 64'h4_0000, 64'h0000_0000_03C4_BEEF,
        64'hA000_0001_2345_8000, "R3 R7 ro 64k");
    // R3 code 5 with write
    run(1, 1, 3'd5, 64'h8_0000, 64'h0000_0000_7FFF_1234,
        64'hA000_00AB_CDEF_0002, "R3 R7 rw code5");
    // R4 unsupported
    run(1, 1, 3'd6, 64'h8_0000, 64'h0000_0000_1234_5678, 64'h0, "R4 code6");
    run(1, 1, 3'd7, 64'h8_0000, 64'h0000_0000_1234_5678, 64'h0, "R4 code7");
    // R5 invalid entry
    run(1, 0, 3'd2, 64'h10_0000, 64'h0000_0000_0123_4567,
        64'h7FFF_FFFF_FFFF_FFFF, "R5 invalid");
    // R7 64K page inside an 8K-granular table
    run(1, 0, 3'd1, 64'h30_0000, 64'h0000_0000_00FE_DCBA,
        64'hA000_0000_7777_0002, "R7 mixed page");
    // R1 again after enabled traffic
    run(0, 1, 3'd7, 64'h8_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R1 passthrough ones");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule